// File: doc/BRIEF.md
# Shift, Rotate and Bit-Test Unit

This unit is the read-modify-write datapath of an 8/16-bit accumulator processor. One start pulse presents an operation code, a width mode, the accumulator, an index register, a fetched memory operand and the current flags. The unit computes a shifted, rotated, incremented, decremented, masked or compared value and the new N, V, Z and C flags. It also reports whether the operation spends one extra internal cycle.

When the destination is memory, the unit streams the new value out through a byte-wide write port. An offset bit selects address+1 or the base address. In 16-bit mode the high byte is written first, and a done pulse follows the last write. Bus timing, address generation and opcode decode stay with the surrounding core.

Operation codes on `op_i`: 0 shift left, 1 logical shift right, 2 rotate left, 3 rotate right, 4 increment, 5 decrement, 6 bit test, 7 test-and-set, 8 test-and-reset, 9 compare. Codes 10 to 15 are reserved. Flags are packed as bit 3 N, bit 2 V, bit 1 Z, bit 0 C, and Z=1 means a zero outcome. The active width is 16 bits when `wide_i`=1 and 8 bits otherwise.

Top module: `rmw_alu`

## Requirements
- R1: Shift left (0) moves the active top bit into C and fills bit 0 with 0. Logical shift right (1) moves bit 0 into C and fills the top bit with 0. Both set N from the result's top bit and Z from result==0, and keep V.
- R2: Rotate left (2) puts the incoming C into bit 0 and the old top bit into C. Rotate right (3) puts the incoming C into the top bit and the old bit 0 into C. N and Z follow the result and V is kept.
- R3: Increment (4) and decrement (5) wrap at the active width and update only N and Z. V and C are kept.
- R4: Bit test (6) sets N from the operand's top bit, V from operand bit 14 (16-bit) or bit 6 (8-bit), and Z from (A AND operand)==0. C is kept, nothing is written, and result_o equals acc_i.
- R5: Test-and-set (7) produces operand OR A, and test-and-reset (8) produces operand AND NOT A. Both always target memory, set Z from (A AND operand)==0, and keep N, V and C.
- R6: Compare (9) subtracts the operand from A (use_idx_i=0) or from the index input (use_idx_i=1). C is set when there is no borrow, and N and Z come from the difference. V is kept, nothing is written, and result_o equals acc_i.
- R7: A memory-target write of a 16-bit result issues two strobes on consecutive cycles. The first has wr_hi_o=1 (address+1) and carries the high byte; the second has wr_hi_o=0 and carries the low byte. An 8-bit result issues one strobe with wr_hi_o=0. In 8-bit memory mode result_o has a zero high byte.
- R8: done_o pulses for one cycle: the cycle after the last write strobe, or the cycle after start when nothing is written.
- R9: With to_acc_i=1, codes 0 to 5 operate on acc_i and issue no write strobe. In 8-bit mode result_o keeps acc_i's high byte.
- R10: extra_o is 1 for codes 0 to 5 and 7 to 8, and 0 for bit test, compare and reserved codes. Reserved codes also keep all flags and write nothing.
- R11: After reset, result_o and flags_o are zero and wr_en_o, done_o and extra_o are low.
- R12: result_o, flags_o and extra_o take their new values in the cycle after start_i and hold them until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request; all operand inputs sampled with it |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 = 16-bit, 0 = 8-bit |
| to_acc_i | input | 1 | Codes 0-5 act on the accumulator instead of memory |
| use_idx_i | input | 1 | Compare against index input instead of accumulator |
| acc_i | input | 16 | Accumulator |
| idx_i | input | 16 | Index register value |
| mem_i | input | 16 | Memory operand |
| flags_i | input | 4 | Current {N,V,Z,C} |
| result_o | output | 16 | Computed value |
| flags_o | output | 4 | Updated {N,V,Z,C} |
| extra_o | output | 1 | Operation spends one extra internal cycle |
| wr_en_o | output | 1 | Byte write strobe |
| wr_hi_o | output | 1 | Write targets address+1 (1) or address (0) |
| wr_data_o | output | 8 | Write byte |
| done_o | output | 1 | Operation complete |

## Verification
Result, flags and the extra-cycle bit are registered on the start edge. They are due in the first cycle after start and are sampled on the falling edge of that cycle. The first write strobe also appears in that cycle, the low-byte strobe one cycle later in 16-bit mode, and done_o one cycle after the last strobe. The bench walks the cycles in that order and samples each at mid-cycle. It then checks one idle cycle further to confirm that done_o has dropped and that the results are still held.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [3:0] {
    OP_SHL  = 4'd0,
    OP_SHR  = 4'd1,
    OP_ROL  = 4'd2,
    OP_ROR  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_TST  = 4'd6,
    OP_SETB = 4'd7,
    OP_CLRB = 4'd8,
    OP_CMP  = 4'd9
  } op_e;

  localparam int FL_N = 3;
  localparam int FL_V = 2;
  localparam int FL_Z = 1;
  localparam int FL_C = 0;
endpackage

// File: rtl/rmw_calc.sv
module rmw_calc
  import rmw_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    op_i,
  input  logic          wide_i,
  input  logic          to_acc_i,
  input  logic          use_idx_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] idx_i,
  input  logic [DW-1:0] mem_i,
  input  logic [3:0]    flags_i,
  output logic [DW-1:0] res_o,
  output logic [3:0]    flags_o,
  output logic          wr_req_o,
  output logic          extra_o
);
  localparam int HW = DW / 2;
  localparam int IW = $clog2(DW);

  op_e           op;
  logic [DW-1:0] mask, src, r, opnd, ref_v, diff;
  logic [DW:0]   sub;
  logic [IW-1:0] ti;
  logic          modify;

  always_comb begin
    op     = op_e'(op_i);
    mask   = wide_i ? {DW{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};
    ti     = wide_i ? IW'(DW - 1) : IW'(HW - 1);
    modify = op inside {OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_INC, OP_DEC};
    opnd   = mem_i & mask;
    src    = (modify && to_acc_i) ? (acc_i & mask) : opnd;
    ref_v  = (use_idx_i ? idx_i : acc_i) & mask;
    sub    = {1'b0, ref_v} - {1'b0, opnd};
    diff   = sub[DW-1:0] & mask;
    r        = '0;
    flags_o  = flags_i;
    res_o    = acc_i;
    wr_req_o = 1'b0;
    extra_o  = 1'b0;
    unique case (op)
      OP_SHL: begin r = (src << 1) & mask; flags_o[FL_C] = src[ti]; end
      OP_SHR: begin r = src >> 1;          flags_o[FL_C] = src[0];  end
      OP_ROL: begin
        r = ((src << 1) | {{(DW-1){1'b0}}, flags_i[FL_C]}) & mask;
        flags_o[FL_C] = src[ti];
      end
      OP_ROR: begin
        r = (src >> 1) | ({{(DW-1){1'b0}}, flags_i[FL_C]} << ti);
        flags_o[FL_C] = src[0];
      end
      OP_INC: r = (src + 1'b1) & mask;
      OP_DEC: r = (src - 1'b1) & mask;
      OP_TST: begin
        flags_o[FL_N] = opnd[ti];
        flags_o[FL_V] = opnd[ti-1];
        flags_o[FL_Z] = (acc_i & opnd) == '0;
      end
      OP_SETB, OP_CLRB: begin
        r = (op == OP_SETB) ? ((opnd | acc_i) & mask) : (opnd & ~acc_i);
        flags_o[FL_Z] = (acc_i & opnd) == '0;
        res_o    = r;
        wr_req_o = 1'b1;
        extra_o  = 1'b1;
      end
      OP_CMP: begin
        flags_o[FL_C] = ~sub[DW];
        flags_o[FL_N] = diff[ti];
        flags_o[FL_Z] = diff == '0;
      end
      default: ;
    endcase
    if (modify) begin
      flags_o[FL_N] = r[ti];
      flags_o[FL_Z] = r == '0;
      extra_o  = 1'b1;
      wr_req_o = ~to_acc_i;
      res_o    = to_acc_i ? ((acc_i & ~mask) | r) : r;
    end
  end
endmodule

// File: rtl/rmw_wb_seq.sv
module rmw_wb_seq #(
  parameter int DW = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               wr_req_i,
  input  logic               wide_i,
  input  logic [DW-1:0]      data_i,
  output logic               wr_en_o,
  output logic               wr_hi_o,
  output logic [DW/2-1:0]    wr_data_o,
  output logic               done_o
);
  localparam int HW = DW / 2;

  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO, S_FIN} st_e;
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start_i)
      st_d = !wr_req_i ? S_FIN : (wide_i ? S_HI : S_LO);
    else
      unique case (st_q)
        S_HI:    st_d = S_LO;
        S_LO:    st_d = S_FIN;
        S_FIN:   st_d = S_IDLE;
        default: st_d = S_IDLE;
      endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;

  assign wr_en_o   = (st_q == S_HI) || (st_q == S_LO);
  assign wr_hi_o   = st_q == S_HI;
  assign wr_data_o = (st_q == S_HI) ? data_i[DW-1:HW] : data_i[HW-1:0];
  assign done_o    = st_q == S_FIN;
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu #(
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [3:0]      op_i,
  input  logic            wide_i,
  input  logic            to_acc_i,
  input  logic            use_idx_i,
  input  logic [DW-1:0]   acc_i,
  input  logic [DW-1:0]   idx_i,
  input  logic [DW-1:0]   mem_i,
  input  logic [3:0]      flags_i,
  output logic [DW-1:0]   result_o,
  output logic [3:0]      flags_o,
  output logic            extra_o,
  output logic            wr_en_o,
  output logic            wr_hi_o,
  output logic [DW/2-1:0] wr_data_o,
  output logic            done_o
);
  logic [DW-1:0] res_d, res_q;
  logic [3:0]    flg_d, flg_q;
  logic          ext_d, ext_q, wr_req;

  rmw_calc #(.DW(DW)) u_calc (
    .op_i(op_i), .wide_i(wide_i), .to_acc_i(to_acc_i), .use_idx_i(use_idx_i),
    .acc_i(acc_i), .idx_i(idx_i), .mem_i(mem_i), .flags_i(flags_i),
    .res_o(res_d), .flags_o(flg_d), .wr_req_o(wr_req), .extra_o(ext_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      res_q <= '0;
      flg_q <= '0;
      ext_q <= 1'b0;
    end else if (start_i) begin
      res_q <= res_d;
      flg_q <= flg_d;
      ext_q <= ext_d;
    end

  rmw_wb_seq #(.DW(DW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .wr_req_i(wr_req),
    .wide_i(wide_i), .data_i(res_q), .wr_en_o(wr_en_o), .wr_hi_o(wr_hi_o),
    .wr_data_o(wr_data_o), .done_o(done_o)
  );

  assign result_o = res_q;
  assign flags_o  = flg_q;
  assign extra_o  = ext_q;
endmodule

// File: rtl/rmw_alu_chk.sv
module rmw_alu_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [3:0] op_i,
  input logic       to_acc_i,
  input logic [3:0] flags_i,
  input logic [3:0] flags_o,
  input logic       extra_o,
  input logic       wr_en_o,
  input logic       wr_hi_o,
  input logic       done_o
);
  p_hi_then_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && wr_hi_o && !start_i |=> wr_en_o && !wr_hi_o);

  p_done_after_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && !wr_hi_o && !start_i |=> done_o && !wr_en_o);

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o);

  p_acc_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && to_acc_i && (op_i <= 4'd5) |=> !wr_en_o);

  p_test_keeps_c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (op_i == 4'd6) |=> flags_o[0] == $past(flags_i[0]));

  p_no_extra_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (op_i == 4'd6 || op_i == 4'd9) |=> !extra_o);
endmodule

bind rmw_alu rmw_alu_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
  .to_acc_i(to_acc_i), .flags_i(flags_i), .flags_o(flags_o), .extra_o(extra_o),
  .wr_en_o(wr_en_o), .wr_hi_o(wr_hi_o), .done_o(done_o)
);

// File: tb/sim_rmw_alu.sv
module sim_rmw_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic        wide = 1'b0, to_acc = 1'b0, use_idx = 1'b0;
  logic [15:0] acc = '0, idx = '0, mem = '0;
  logic [3:0]  fl_in = '0;
  logic [15:0] result;
  logic [3:0]  fl_out;
  logic        extra, wr_en, wr_hi, done;
  logic [7:0]  wr_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rmw_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .wide_i(wide),
    .to_acc_i(to_acc), .use_idx_i(use_idx), .acc_i(acc), .idx_i(idx), .mem_i(mem),
    .flags_i(fl_in), .result_o(result), .flags_o(fl_out), .extra_o(extra),
    .wr_en_o(wr_en), .wr_hi_o(wr_hi), .wr_data_o(wr_data), .done_o(done)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag(int o);
    case (o)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 5: return "R3";
      6: return "R4";
      7, 8: return "R5";
      9: return "R6";
      default: return "R10";
    endcase
  endfunction

  // reference model written from the requirement list
  function automatic void model(output int er, output int ef, output bit ew, output bit ex);
    int w = wide ? 16 : 8;
    int m = (1 << w) - 1;
    int t = 1 << (w - 1);
    int a = acc & m, o = mem & m;
    int c = fl_in[0];
    int n = fl_in[3], v = fl_in[2], z = fl_in[1];
    int s, r;
    bit mod = op <= 5;
    s = (mod && to_acc) ? a : o;
    er = acc; ew = 0; ex = 0; r = 0;
    case (op)
      0: begin r = (s * 2) % (m + 1); c = (s & t) ? 1 : 0; end
      1: begin r = s / 2; c = s % 2; end
      2: begin r = (s * 2 + c) % (m + 1); c = (s & t) ? 1 : 0; end
      3: begin r = s / 2 + (c ? t : 0); c = s % 2; end
      4: r = (s + 1) % (m + 1);
      5: r = (s + m) % (m + 1);
      6: begin n = (o & t) ? 1 : 0; v = (o & (t / 2)) ? 1 : 0; z = ((a & o) == 0); end
      7, 8: begin
        r = (op == 7) ? (o | a) : (o & (~a & m));
        z = ((a & o) == 0); er = r; ew = 1; ex = 1;
      end
      9: begin
        s = (use_idx ? idx : acc) & m;
        c = (s >= o);
        r = (s - o + m + 1) % (m + 1);
        n = (r & t) ? 1 : 0; z = (r == 0);
      end
      default: ;
    endcase
    if (mod) begin
      n = (r & t) ? 1 : 0; z = (r == 0); ex = 1; ew = !to_acc;
      er = to_acc ? ((acc & ~m & 16'hFFFF) | r) : r;
    end
    ef = (n << 3) | (v << 2) | (z << 1) | c;
  endfunction

  task automatic run(int o, bit wd, bit ta, bit ui, int a, int x, int mv, int f);
    int er, ef;
    bit ew, ex;
    string t;
    @(negedge clk);
    op = 4'(o); wide = wd; to_acc = ta; use_idx = ui;
    acc = 16'(a); idx = 16'(x); mem = 16'(mv); fl_in = 4'(f);
    model(er, ef, ew, ex);
    t = tag(o);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // cycle 1: registered results due (R12)
    chk(t, "result", result, er);
    chk(t, "flags", fl_out, ef);
    chk("R10", "extra", extra, ex);
    if (ew && wd) begin
      chk("R7", "hi strobe", {wr_en, wr_hi}, 2'b11);
      chk("R7", "hi byte", wr_data, er >> 8);
      @(negedge clk);
      chk("R7", "lo strobe", {wr_en, wr_hi}, 2'b10);
      chk("R7", "lo byte", wr_data, er & 255);
      @(negedge clk);
    end else if (ew) begin
      chk("R7", "byte strobe", {wr_en, wr_hi}, 2'b10);
      chk("R7", "byte", wr_data, er & 255);
      @(negedge clk);
    end else if (ta && o <= 5) begin
      chk("R9", "no strobe", wr_en, 0);
    end
    chk("R8", "done", {done, wr_en}, 2'b10);
    @(negedge clk);
    chk("R8", "done drop", done, 0);
    chk("R12", "held result", result, er);
    chk("R12", "held flags", fl_out, ef);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #35;
    chk("R11", "reset result", result, 0);
    chk("R11", "reset flags", fl_out, 0);
    chk("R11", "reset strobes", {wr_en, done, extra}, 0);
    rst_n = 1'b1;
    // directed corners
    run(0, 1, 0, 0, 0, 0, 16'h8000, 0);      // R1 shift out top, zero result
    run(1, 0, 1, 0, 16'hAB01, 0, 0, 4'h4);   // R1/R9 acc 8-bit keeps high byte
    run(2, 0, 0, 0, 0, 0, 16'h0080, 1);      // R2 rotate carry in
    run(3, 1, 1, 0, 16'h0001, 0, 0, 1);      // R2 carry into bit 15
    run(4, 0, 0, 0, 0, 0, 16'h00FF, 4'hD);   // R3 wrap 8-bit
    run(5, 1, 0, 0, 0, 0, 16'h0000, 4'h4);   // R3 wrap 16-bit
    run(6, 1, 0, 0, 16'h00FF, 0, 16'h4000, 1); // R4 V from bit 14
    run(6, 0, 0, 0, 16'h0000, 0, 16'h00C0, 0); // R4 8-bit
    run(7, 1, 0, 0, 16'h0F0F, 0, 16'hF000, 4'hC); // R5 set
    run(8, 0, 0, 0, 16'h000F, 0, 16'h00FF, 4'hC); // R5 reset
    run(9, 0, 0, 1, 16'h0000, 16'h0042, 16'h0042, 4'h4); // R6 equal, index
    run(9, 1, 0, 0, 16'h0001, 0, 16'h0002, 0); // R6 borrow
    run(12, 1, 0, 0, 16'h1234, 0, 16'h5678, 4'hA); // R10 reserved
    for (int i = 0; i < 300; i++)
      run($urandom_range(0, 11), 1'($urandom), 1'($urandom), 1'($urandom),
          $urandom & 16'hFFFF, $urandom & 16'hFFFF, $urandom & 16'hFFFF, $urandom & 15);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule